// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind a serial-bus protocol engine on the write path of a byte-addressed storage array. It collects the data bytes of one page write in a small staging buffer, then copies them into the array during one timed program window after the bus master ends the transfer. The protocol engine gives it three inputs: a load strobe with the starting address, one strobe per received data byte, and a commit pulse when the transfer ends. While the program window runs, the block drives a busy flag and ignores all three inputs. The protocol engine also uses that flag to stay off the bus.

Each page holds 32 bytes. The five low address bits select the slot in the page and the bits above them select the page. As bytes arrive, only the slot number advances, so a burst longer than one page wraps and overwrites slots it filled earlier. A per-slot mark records which slots were filled. Only those slots reach the array, at one byte per clock early in the busy window. The block also keeps the shared address pointer that the read path uses.

When the write-protect input is high, the top quarter of the address space is read-only. With 13 address bits that region is 0x1800 to 0x1FFF. The default build has 11 address bits, so the protected region is 0x600 to 0x7FF. A simple synchronous RAM model stands in for the array and has one read port for the read path. When load, byte and commit strobes arrive in the same cycle, the load wins over the byte, and the byte wins over the commit.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and `ptr` is 0.
- R2: A byte accepted after a load of address A is placed in slot A[4:0] of page A[ADDR_W-1:5]. Each later byte goes to the next slot, modulo 32, and the page bits do not change. After commit, each byte is held at address {page, slot}.
- R3: If more than 32 bytes arrive before the commit pulse, the slot number wraps from 31 to 0. A later byte overwrites the earlier byte in the same slot.
- R4: Commit writes only the slots that received a byte since the last load. All other locations in the page keep their old contents.
- R5: No array location changes before the commit pulse. Bytes still waiting in the buffer do not appear on the read port.
- R6: An accepted commit pulse that has at least one buffered byte and is not protected starts the program window. `busy` goes high in the cycle after the pulse is sampled and stays high for exactly WCYC cycles.
- R7: While `busy` is high, load, byte and commit strobes are ignored. They do not change `ptr`, the array, or the buffer, and they do not start a second window.
- R8: A commit pulse with no buffered bytes does not raise `busy`. After such a pulse, `ptr` holds the loaded address.
- R9: When `wp_in` is 1 at the commit pulse and the two top address bits of the page are both 1, `busy` stays 0 and no location is written. If either of those bits is 0, or `wp_in` is 0, the commit goes ahead.
- R10: `ptr` takes the loaded address on a load, and the address of each byte as that byte is accepted. After commit it therefore holds the address of the last byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_in | input | 1 | Write protect; 1 makes the top quarter read-only |
| start_vld | input | 1 | Load the starting address and clear the slot marks |
| start_addr | input | ADDR_W | Starting address of the page write |
| byte_vld | input | 1 | One data byte received |
| byte_dat | input | DATA_W | Received data byte |
| stop_pls | input | 1 | End of transfer; commit request |
| busy | output | 1 | Program window active |
| ptr | output | ADDR_W | Shared address pointer |
| rd_addr | input | ADDR_W | Array read address |
| rd_dat | output | DATA_W | Array read data, one cycle after `rd_addr` |

## Verification
The inputs are driven on the falling edge, so each strobe is taken on the next rising edge. `ptr` moves on that same rising edge, and the bench reads it at the following falling edge. `busy` is due at the first falling edge after the commit pulse is sampled. The bench counts falling edges at which `busy` is still high and expects exactly WCYC. The read port has one register stage, so each read sets the address on one falling edge and samples `rd_dat` on the next. Array contents are read only after `busy` has dropped, when the serial copy has already finished.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_PROG = 1'b1
   } seq_st_e;
endpackage

// File: rtl/pgwr_ram.sv
module pgwr_ram #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdat,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdat
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   initial begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] = '0;
   end

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdat;
      rdat <= mem_q[raddr];
   end
endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter int LOW_W  = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load,
   input  logic [ADDR_W-1:0]             load_addr,
   input  logic                          push,
   input  logic [DATA_W-1:0]             push_dat,
   input  logic                          clr,
   input  logic [LOW_W-1:0]              rd_idx,
   output logic [(1<<LOW_W)-1:0]         mask,
   output logic [DATA_W-1:0]             rd_dat,
   output logic [ADDR_W-LOW_W-1:0]       page,
   output logic [ADDR_W-1:0]             ptr
);
   localparam int SLOTS = 1 << LOW_W;
   localparam int PG_W  = ADDR_W - LOW_W;

   logic [LOW_W-1:0]              low_q;
   logic [PG_W-1:0]               page_q;
   logic [ADDR_W-1:0]             ptr_q;
   logic [SLOTS-1:0][DATA_W-1:0]  slot_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         page_q <= '0;
         ptr_q  <= '0;
      end else if (load) begin
         page_q <= load_addr[ADDR_W-1:LOW_W];
         low_q  <= load_addr[LOW_W-1:0];
         ptr_q  <= load_addr;
      end else if (push) begin
         low_q  <= low_q + 1'b1;
         ptr_q  <= {page_q, low_q};
      end
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic              hit;
      logic              mark_q;
      logic [DATA_W-1:0] dat_q;

      assign hit = push && !load && (low_q == LOW_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           mark_q <= 1'b0;
         else if (load || clr) mark_q <= 1'b0;
         else if (hit)         mark_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit) dat_q <= push_dat;
      end

      assign mask[g]      = mark_q;
      assign slot_flat[g] = dat_q;
   end

   assign rd_dat = slot_flat[rd_idx];
   assign page   = page_q;
   assign ptr    = ptr_q;

   // R2, R3: slot advances modulo the page, page bits hold
   a_r3_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !load) |=> ($stable(page_q) && (low_q == $past(low_q) + 1'b1)));
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
   import pgwr_pkg::*;
#(
   parameter int LOW_W = 5,
   parameter int WCYC  = 500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             any,
   input  logic             prot,
   output logic             busy,
   output logic             scan_act,
   output logic [LOW_W-1:0] idx,
   output logic             clr
);
   localparam int SLOTS = 1 << LOW_W;
   localparam int TW    = $clog2(WCYC + 1);

   seq_st_e         st_q;
   logic [TW-1:0]   tmr_q;
   logic [LOW_W:0]  scan_q;
   logic            go;
   logic            done;

   assign go   = stop && any && !prot;
   assign done = (st_q == ST_PROG) && (tmr_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         tmr_q  <= '0;
         scan_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (go) begin
                  st_q   <= ST_PROG;
                  tmr_q  <= TW'(WCYC - 1);
                  scan_q <= '0;
               end
            end
            ST_PROG: begin
               if (tmr_q == '0) st_q  <= ST_IDLE;
               else             tmr_q <= tmr_q - 1'b1;
               if (!scan_q[LOW_W]) scan_q <= scan_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st_q == ST_PROG);
   assign scan_act = busy && !scan_q[LOW_W];
   assign idx      = scan_q[LOW_W-1:0];
   assign clr      = (stop && !go) || done;

   // R6: a window opens only after an accepted commit pulse
   a_r6_open_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop));

   // R4: every slot has been visited by the time the window closes
   a_r4_scan_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (scan_q == (LOW_W+1)'(SLOTS)));
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter int LOW_W  = 5,
   parameter int WCYC   = 500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_in,
   input  logic              start_vld,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_dat,
   input  logic              stop_pls,
   output logic              busy,
   output logic [ADDR_W-1:0] ptr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_dat
);
   localparam int SLOTS = 1 << LOW_W;
   localparam int PG_W  = ADDR_W - LOW_W;

   if (PG_W < 2) begin : g_bad_addr
      $error("ADDR_W must exceed LOW_W by at least 2");
   end
   if (WCYC < SLOTS) begin : g_bad_wcyc
      $error("WCYC must cover one cycle per page slot");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic              load, push, stop_ok;
   logic              clr, scan_act, prot, ram_we;
   logic [SLOTS-1:0]  mask;
   logic [DATA_W-1:0] slot_dat;
   logic [PG_W-1:0]   page;
   logic [LOW_W-1:0]  idx;

   assign load    = start_vld && !busy;
   assign push    = byte_vld && !busy && !start_vld;
   assign stop_ok = stop_pls && !busy && !start_vld && !byte_vld;
   assign prot    = wp_in && (page[PG_W-1 -: 2] == 2'b11);

   pgwr_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (start_addr),
      .push      (push),
      .push_dat  (byte_dat),
      .clr       (clr),
      .rd_idx    (idx),
      .mask      (mask),
      .rd_dat    (slot_dat),
      .page      (page),
      .ptr       (ptr)
   );

   pgwr_seq #(.LOW_W(LOW_W), .WCYC(WCYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop     (stop_ok),
      .any      (|mask),
      .prot     (prot),
      .busy     (busy),
      .scan_act (scan_act),
      .idx      (idx),
      .clr      (clr)
   );

   assign ram_we = scan_act && mask[idx];

   pgwr_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr ({page, idx}),
      .wdat  (slot_dat),
      .raddr (rd_addr),
      .rdat  (rd_dat)
   );

   // R7: pointer frozen across the program window
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ptr));

   // R8: empty commit opens no window
   a_r8_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ok && (mask == '0)) |=> !busy);

   // R9: protected commit opens no window
   a_r9_protected: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ok && prot) |=> !busy);
endmodule

// File: tb/test_page_write_ctrl.sv
module test_page_write_ctrl;
   localparam int AW = 11;
   localparam int WC = 40;

   typedef struct packed {
      logic          wp;
      logic [6:0]    n;
      logic [7:0]    seed;
      logic [AW-1:0] addr;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{wp: 1'b0, n: 7'd3,  seed: 8'h10, addr: 11'h045},
      '{wp: 1'b0, n: 7'd5,  seed: 8'h20, addr: 11'h1FE},
      '{wp: 1'b0, n: 7'd32, seed: 8'h40, addr: 11'h100},
      '{wp: 1'b0, n: 7'd35, seed: 8'h80, addr: 11'h0A3},
      '{wp: 1'b1, n: 7'd4,  seed: 8'hC0, addr: 11'h640},
      '{wp: 1'b0, n: 7'd4,  seed: 8'hD0, addr: 11'h640},
      '{wp: 1'b1, n: 7'd2,  seed: 8'hE0, addr: 11'h7E0},
      '{wp: 1'b1, n: 7'd3,  seed: 8'hF0, addr: 11'h5F0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_in = 1'b0;
   logic          start_vld = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          byte_vld = 1'b0;
   logic [7:0]    byte_dat = '0;
   logic          stop_pls = 1'b0;
   logic          busy;
   logic [AW-1:0] ptr;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_dat;

   int checks = 0;
   int errors = 0;
   logic [7:0] mdl [1 << AW];

   always #10 clk = ~clk;

   page_write_ctrl #(.ADDR_W(AW), .DATA_W(8), .LOW_W(5), .WCYC(WC)) i_page_write_ctrl (
      .clk(clk), .rst_n(rst_n), .wp_in(wp_in), .start_vld(start_vld),
      .start_addr(start_addr), .byte_vld(byte_vld), .byte_dat(byte_dat),
      .stop_pls(stop_pls), .busy(busy), .ptr(ptr), .rd_addr(rd_addr), .rd_dat(rd_dat)
   );

   task automatic chk(input logic ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic do_start(input logic [AW-1:0] a);
      @(negedge clk); start_vld = 1'b1; start_addr = a;
      @(negedge clk); start_vld = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] d);
      @(negedge clk); byte_vld = 1'b1; byte_dat = d;
      @(negedge clk); byte_vld = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk); stop_pls = 1'b1;
      @(negedge clk); stop_pls = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge clk); rd_addr = a;
      @(negedge clk); d = rd_dat;
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic check_page(input logic [AW-1:0] a, input string req);
      logic [7:0] d;
      for (int s = 0; s < 32; s++) begin
         logic [AW-1:0] x;
         x = {a[AW-1:5], 5'(s)};
         rd(x, d);
         chk(d == mdl[x], req, d, mdl[x]);
      end
   endtask

   initial begin
      for (int k = 0; k < (1 << AW); k++) mdl[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(ptr == '0, "R1 ptr", ptr, 0);

      // Table walk: R2 R3 R4 R6 R9 R10
      for (int v = 0; v < 8; v++) begin
         logic          pr;
         int            n;
         logic [AW-1:0] ep;
         wp_in = VEC[v].wp;
         pr = VEC[v].wp && (VEC[v].addr[AW-1 -: 2] == 2'b11);
         do_start(VEC[v].addr);
         for (int i = 0; i < int'(VEC[v].n); i++) begin
            logic [AW-1:0] x;
            x = {VEC[v].addr[AW-1:5], 5'(int'(VEC[v].addr[4:0]) + i)};
            do_byte(VEC[v].seed + 8'(i));
            if (!pr) mdl[x] = VEC[v].seed + 8'(i);
         end
         ep = {VEC[v].addr[AW-1:5], 5'(int'(VEC[v].addr[4:0]) + int'(VEC[v].n) - 1)};
         chk(ptr == ep, "R10 ptr after bytes", ptr, ep);
         do_stop();
         chk(busy == !pr, "R9/R6 busy after commit", busy, !pr);
         count_busy(n);
         chk(n == (pr ? 0 : WC), "R6 busy length", n, pr ? 0 : WC);
         wp_in = 1'b0;
         check_page(VEC[v].addr, pr ? "R9 protected page" : "R2/R3/R4 page contents");
      end

      // R5: nothing visible before the commit pulse
      begin
         logic [7:0] d;
         do_start(11'h300);
         do_byte(8'hAA);
         do_byte(8'hBB);
         rd(11'h300, d);
         chk(d == 8'h00, "R5 no write before stop", d, 0);
         chk(busy == 1'b0, "R5 idle before stop", busy, 0);
         do_stop();
         mdl[11'h300] = 8'hAA; mdl[11'h301] = 8'hBB;
         while (busy) @(negedge clk);
         rd(11'h301, d);
         chk(d == 8'hBB, "R5 written after stop", d, 8'hBB);
      end

      // R8: empty commit
      begin
         do_start(11'h123);
         do_stop();
         chk(busy == 1'b0, "R8 no busy on empty stop", busy, 0);
         repeat (3) @(negedge clk);
         chk(busy == 1'b0, "R8 still idle", busy, 0);
         chk(ptr == 11'h123, "R8 ptr holds load address", ptr, 11'h123);
      end

      // R7: strobes ignored during window
      begin
         logic [7:0] d;
         do_start(11'h010);
         do_byte(8'h55);
         do_stop();
         mdl[11'h010] = 8'h55;
         chk(busy == 1'b1, "R7 window open", busy, 1);
         do_start(11'h400);
         do_byte(8'h77);
         do_stop();
         chk(ptr == 11'h010, "R7 ptr unchanged in window", ptr, 11'h010);
         while (busy) @(negedge clk);
         repeat (2) @(negedge clk);
         chk(busy == 1'b0, "R7 no second window", busy, 0);
         chk(ptr == 11'h010, "R7 ptr after window", ptr, 11'h010);
         rd(11'h400, d);
         chk(d == mdl[11'h400], "R7 ignored byte not written", d, mdl[11'h400]);
         rd(11'h010, d);
         chk(d == 8'h55, "R7 real byte written", d, 8'h55);
         do_stop();
         chk(busy == 1'b0, "R7 stale buffer not recommitted", busy, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule